// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core completes one instruction per clock. In a single combinational pass it reads the instruction at the program counter, decodes it, reads two source registers and computes in the ALU. It then touches data memory when needed and selects the value to write back. The register file and data memory commit on the next rising edge, and the program counter takes its next value on that same edge.

The instruction set covers five register-register operations: add, subtract, and, or and signed set-less-than. It also covers add-immediate, word load, word store and branch-if-equal.

Instruction memory is word addressed. It is filled through a small load port while reset is held. A debug port shows the current program counter and the register write the core will commit at the end of the current cycle. An instruction trace can therefore be compared against a reference model one cycle at a time.

Top module: `mcpu_core`

## Requirements
- R1: While `rst` is high on a rising edge, the program counter becomes 0. On the first cycle after reset the core executes the instruction at word 0.
- R2: Every instruction other than a taken branch moves the program counter to PC+4 on the next rising edge.
- R3: Opcode 0 with funct 0x20, 0x22, 0x24, 0x25 or 0x2A writes rs+rt, rs-rt, rs&rt, rs|rt or (signed rs<rt ? 1 : 0) to register rd, taken from instruction bits 15:11.
- R4: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate (bits 15:0) to register rt, taken from instruction bits 20:16.
- R5: Opcode 0x23 loads the data word at rs plus the sign-extended offset into rt. Opcode 0x2B stores rt at that address and writes no register. Data memory never reads and writes in the same cycle.
- R6: Opcode 0x04 with equal rs and rt moves the PC to PC+4+(sign-extended immediate × 4). With unequal operands it moves the PC to PC+4. It writes no register.
- R7: Register 0 always reads as zero. A write aimed at it is dropped, and `dbg_we` stays low for that write.
- R8: During each cycle, `dbg_we`, `dbg_waddr` and `dbg_wdata` show the register write that the coming rising edge commits. `dbg_pc` shows the address of the instruction being executed.
- R9: A non-branch instruction whose ALU result is zero does not redirect the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Instruction memory load strobe |
| ld_addr | input | 6 | Instruction memory word index for loading |
| ld_data | input | 32 | Instruction word to load |
| dbg_pc | output | 32 | Address of the instruction in execution |
| dbg_we | output | 1 | A register write commits at the next edge |
| dbg_waddr | output | 5 | Destination register of that write |
| dbg_wdata | output | 32 | Value of that write |

## Verification
All debug outputs are combinational views of the current instruction, so each result is due in the cycle of its instruction. The bench samples the results on the falling edge that follows the rising edge that fetched the instruction. The program counter, register contents and memory contents take the effect of an instruction one rising edge later. The bench reference model updates its own state after each comparison, mirroring that edge. Its next comparison therefore sees the consequences of stores, loads and branches exactly one cycle after they issue.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

   localparam int XLEN    = 32;
   localparam int RIDX_W  = 5;
   localparam int NREGS   = 1 << RIDX_W;

   typedef enum logic [5:0] {
      OP_RTYPE = 6'h00,
      OP_BEQ   = 6'h04,
      OP_ADDI  = 6'h08,
      OP_LW    = 6'h23,
      OP_SW    = 6'h2B
   } opcode_e;

   typedef enum logic [5:0] {
      FN_ADD = 6'h20,
      FN_SUB = 6'h22,
      FN_AND = 6'h24,
      FN_OR  = 6'h25,
      FN_SLT = 6'h2A
   } funct_e;

   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111
   } alu_op_e;

   typedef enum logic [1:0] {
      AC_ADD   = 2'b00,
      AC_SUB   = 2'b01,
      AC_FUNCT = 2'b10
   } alu_class_e;

   typedef struct packed {
      logic       reg_dst;
      logic       alu_src;
      logic       mem_to_reg;
      logic       reg_write;
      logic       mem_read;
      logic       mem_write;
      logic       branch;
      alu_class_e alu_class;
   } ctrl_t;

endpackage

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
   import mcpu_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctl,
   output alu_op_e    alu_op
);

   always_comb begin
      ctl = '0;
      ctl.alu_class = AC_ADD;
      case (opcode)
         OP_RTYPE: begin
            ctl.reg_dst   = 1'b1;
            ctl.reg_write = 1'b1;
            ctl.alu_class = AC_FUNCT;
         end
         OP_ADDI: begin
            ctl.alu_src   = 1'b1;
            ctl.reg_write = 1'b1;
         end
         OP_LW: begin
            ctl.alu_src    = 1'b1;
            ctl.mem_to_reg = 1'b1;
            ctl.reg_write  = 1'b1;
            ctl.mem_read   = 1'b1;
         end
         OP_SW: begin
            ctl.alu_src   = 1'b1;
            ctl.mem_write = 1'b1;
         end
         OP_BEQ: begin
            ctl.branch    = 1'b1;
            ctl.alu_class = AC_SUB;
         end
         default: ctl = '0;
      endcase
   end

   always_comb begin
      case (ctl.alu_class)
         AC_ADD: alu_op = ALU_ADD;
         AC_SUB: alu_op = ALU_SUB;
         AC_FUNCT: begin
            case (funct)
               FN_ADD:  alu_op = ALU_ADD;
               FN_SUB:  alu_op = ALU_SUB;
               FN_AND:  alu_op = ALU_AND;
               FN_OR:   alu_op = ALU_OR;
               FN_SLT:  alu_op = ALU_SLT;
               default: alu_op = ALU_ADD;
            endcase
         end
         default: alu_op = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
   import mcpu_pkg::*;
#(
   parameter int  WIDTH      = 32,
   parameter bit  SLT_SIGNED = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] y,
   output logic             zero
);

   if (WIDTH < 2) begin : g_bad_width
      $error("mcpu_alu: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] diff;
   logic             less;

   assign diff = a - b;

   if (SLT_SIGNED) begin : g_slt_signed
      assign less = $signed(a) < $signed(b);
   end else begin : g_slt_unsigned
      assign less = a < b;
   end

   always_comb begin
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_ADD: y = a + b;
         ALU_SUB: y = diff;
         ALU_SLT: y = {{(WIDTH-1){1'b0}}, less};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
   parameter int WIDTH  = 32,
   parameter int IDX_W  = 5
) (
   input  logic             clk,
   input  logic [IDX_W-1:0] ra1,
   input  logic [IDX_W-1:0] ra2,
   output logic [WIDTH-1:0] rd1,
   output logic [WIDTH-1:0] rd2,
   input  logic             we,
   input  logic [IDX_W-1:0] wa,
   input  logic [WIDTH-1:0] wd
);

   localparam int DEPTH = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("mcpu_regfile: IDX_W out of range");
   end

   logic [WIDTH-1:0] regs [DEPTH];

   always_ff @(posedge clk) begin
      if (we && wa != '0) regs[wa] <= wd;
   end

   assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
   assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mcpu_wmem.sv
module mcpu_wmem #(
   parameter int WIDTH = 32,
   parameter int AW    = 6
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("mcpu_wmem: AW out of range");
   end

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
   import mcpu_pkg::*;
#(
   parameter int IMEM_AW    = 6,
   parameter int DMEM_AW    = 6,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ld_en,
   input  logic [IMEM_AW-1:0] ld_addr,
   input  logic [XLEN-1:0]    ld_data,
   output logic [XLEN-1:0]    dbg_pc,
   output logic               dbg_we,
   output logic [RIDX_W-1:0]  dbg_waddr,
   output logic [XLEN-1:0]    dbg_wdata
);

   localparam int BYTE_SH = 2;

   if (IMEM_AW + BYTE_SH > XLEN || DMEM_AW + BYTE_SH > XLEN) begin : g_bad_aw
      $error("mcpu_core: memory address width exceeds XLEN");
   end

   // fetch
   logic [XLEN-1:0] pc_q, pc_plus4, pc_next, br_target;
   logic [XLEN-1:0] instr;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   assign pc_plus4 = pc_q + XLEN'(4);

   mcpu_wmem #(.WIDTH(XLEN), .AW(IMEM_AW)) imem_i (
      .clk   (clk),
      .we    (ld_en),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (pc_q[BYTE_SH +: IMEM_AW]),
      .rdata (instr)
   );

   // decode
   logic [5:0]        f_op, f_fn;
   logic [RIDX_W-1:0] f_rs, f_rt, f_rd, wr_idx;
   logic [15:0]       f_imm;
   logic [XLEN-1:0]   simm;
   ctrl_t             ctl;
   alu_op_e           alu_op;

   assign f_op  = instr[31:26];
   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign f_fn  = instr[5:0];
   assign f_imm = instr[15:0];
   assign simm  = {{(XLEN-16){f_imm[15]}}, f_imm};

   mcpu_ctrl ctrl_i (
      .opcode (f_op),
      .funct  (f_fn),
      .ctl    (ctl),
      .alu_op (alu_op)
   );

   assign wr_idx = ctl.reg_dst ? f_rd : f_rt;

   logic [XLEN-1:0] rs_val, rt_val, wb_val;

   mcpu_regfile #(.WIDTH(XLEN), .IDX_W(RIDX_W)) rf_i (
      .clk (clk),
      .ra1 (f_rs),
      .ra2 (f_rt),
      .rd1 (rs_val),
      .rd2 (rt_val),
      .we  (ctl.reg_write),
      .wa  (wr_idx),
      .wd  (wb_val)
   );

   // execute
   logic [XLEN-1:0] alu_b, alu_y;
   logic            alu_zero, take_br;

   assign alu_b = ctl.alu_src ? simm : rt_val;

   mcpu_alu #(.WIDTH(XLEN), .SLT_SIGNED(SLT_SIGNED)) alu_i (
      .a    (rs_val),
      .b    (alu_b),
      .op   (alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   assign br_target = pc_plus4 + {simm[XLEN-3:0], 2'b00};
   assign take_br   = ctl.branch & alu_zero;
   assign pc_next   = take_br ? br_target : pc_plus4;

   // memory
   logic [XLEN-1:0] dm_rdata;

   mcpu_wmem #(.WIDTH(XLEN), .AW(DMEM_AW)) dmem_i (
      .clk   (clk),
      .we    (ctl.mem_write),
      .waddr (alu_y[BYTE_SH +: DMEM_AW]),
      .wdata (rt_val),
      .raddr (alu_y[BYTE_SH +: DMEM_AW]),
      .rdata (dm_rdata)
   );

   // writeback
   assign wb_val = ctl.mem_to_reg ? dm_rdata : alu_y;

   assign dbg_pc    = pc_q;
   assign dbg_we    = ctl.reg_write && (wr_idx != '0);
   assign dbg_waddr = wr_idx;
   assign dbg_wdata = wb_val;

endmodule

// File: rtl/mcpu_chk.sv
module mcpu_chk
   import mcpu_pkg::*;
(
   input logic              clk,
   input logic              rst,
   input logic [XLEN-1:0]   pc,
   input ctrl_t             ctl,
   input logic              zero,
   input logic [XLEN-1:0]   simm,
   input logic [RIDX_W-1:0] rs_idx,
   input logic [XLEN-1:0]   rs_val,
   input logic              dbg_we,
   input logic [RIDX_W-1:0] dbg_waddr
);

   AST_PC_RESET: assert property (@(posedge clk) rst |=> pc == '0); // R1

   AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
      !ctl.branch |=> pc == $past(pc) + XLEN'(4)); // R2

   AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (ctl.branch && zero) |=> pc == $past(pc) + XLEN'(4) + {$past(simm[XLEN-3:0]), 2'b00}); // R6

   AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (ctl.branch && !zero) |=> pc == $past(pc) + XLEN'(4)); // R6

   AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(ctl.mem_read && ctl.mem_write)); // R5

   AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
      ctl.mem_write |-> !dbg_we); // R5

   AST_R0_READ: assert property (@(posedge clk) disable iff (rst)
      rs_idx == '0 |-> rs_val == '0); // R7

   AST_R0_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      dbg_we |-> dbg_waddr != '0); // R7

endmodule

bind mcpu_core mcpu_chk chk_i (
   .clk       (clk),
   .rst       (rst),
   .pc        (pc_q),
   .ctl       (ctl),
   .zero      (alu_zero),
   .simm      (simm),
   .rs_idx    (f_rs),
   .rs_val    (rs_val),
   .dbg_we    (dbg_we),
   .dbg_waddr (dbg_waddr)
);

// File: tb/mcpu_core_tb.sv
module mcpu_core_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_en = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [31:0] dbg_pc;
   logic        dbg_we;
   logic [4:0]  dbg_waddr;
   logic [31:0] dbg_wdata;

   always #5 clk = ~clk;

   mcpu_core dut_i (
      .clk       (clk),
      .rst       (rst),
      .ld_en     (ld_en),
      .ld_addr   (ld_addr),
      .ld_data   (ld_data),
      .dbg_pc    (dbg_pc),
      .dbg_we    (dbg_we),
      .dbg_waddr (dbg_waddr),
      .dbg_wdata (dbg_wdata)
   );

   int errors = 0;
   int checks = 0;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   logic [31:0] prog [$];
   logic [31:0] m_reg [32];
   logic [31:0] m_mem [int];
   logic [31:0] m_pc;

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      prog.push_back(enc_i(6'h08, 0, 1, 40));        // addi r1 = 40
      prog.push_back(enc_i(6'h08, 0, 2, -3));        // addi r2 = -3
      prog.push_back(enc_r(1, 2, 3, 6'h20));         // add
      prog.push_back(enc_r(1, 2, 4, 6'h22));         // sub
      prog.push_back(enc_r(1, 2, 5, 6'h24));         // and
      prog.push_back(enc_r(1, 2, 6, 6'h25));         // or
      prog.push_back(enc_r(2, 1, 7, 6'h2A));         // slt true
      prog.push_back(enc_i(6'h2B, 1, 3, -8));        // sw r3, -8(r1)
      prog.push_back(enc_i(6'h23, 1, 8, -8));        // lw r8, -8(r1)
      prog.push_back(enc_i(6'h04, 3, 8, 1));         // beq taken
      prog.push_back(enc_i(6'h08, 0, 9, 99));        // skipped
      prog.push_back(enc_i(6'h04, 1, 2, 2));         // beq not taken
      prog.push_back(enc_i(6'h08, 0, 0, 5));         // write r0
      prog.push_back(enc_r(1, 2, 10, 6'h2A));        // slt false
      prog.push_back(enc_r(1, 1, 12, 6'h22));        // zero result
      prog.push_back(enc_r(0, 1, 11, 6'h20));        // r0 + r1
      prog.push_back(enc_i(6'h04, 0, 0, -1));        // self loop

      foreach (m_reg[i]) m_reg[i] = '0;
      m_pc = '0;

      foreach (prog[i]) begin
         @(negedge clk);
         ld_en   = 1'b1;
         ld_addr = 6'(i);
         ld_data = prog[i];
      end
      @(negedge clk);
      ld_en = 1'b0;
      @(negedge clk);
      check("R1", "pc in reset", dbg_pc, 32'h0);
      rst = 1'b0;

      for (int cyc = 0; cyc < 30; cyc++) begin
         logic [31:0] ins, a, b, res, nxt, simm;
         logic [5:0]  op, fn;
         logic        we;
         logic [4:0]  wa;
         string       rq, pq;
         ins  = prog[m_pc >> 2];
         op   = ins[31:26];
         fn   = ins[5:0];
         a    = m_reg[ins[25:21]];
         b    = m_reg[ins[20:16]];
         simm = {{16{ins[15]}}, ins[15:0]};
         we   = 1'b0;
         wa   = '0;
         res  = '0;
         nxt  = m_pc + 4;
         rq   = "R2";
         pq   = "R2";
         if (op == 6'h00) begin
            rq = "R3";
            wa = ins[15:11];
            we = 1'b1;
            case (fn)
               6'h20: res = a + b;
               6'h22: res = a - b;
               6'h24: res = a & b;
               6'h25: res = a | b;
               default: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            endcase
            if (res == 0) pq = "R9";
         end else if (op == 6'h08) begin
            rq = "R4"; wa = ins[20:16]; we = 1'b1; res = a + simm;
            if (res == 0) pq = "R9";
         end else if (op == 6'h23) begin
            rq = "R5"; wa = ins[20:16]; we = 1'b1;
            res = m_mem.exists(int'(a + simm)) ? m_mem[int'(a + simm)] : 32'h0;
         end else if (op == 6'h2B) begin
            rq = "R5";
            m_mem[int'(a + simm)] = b;
         end else if (op == 6'h04) begin
            rq = "R6"; pq = "R6";
            if (a == b) nxt = m_pc + 4 + (simm << 2);
         end
         if (we && wa == 0) begin
            we = 1'b0;
            rq = "R7";
         end

         check("R8", "pc", dbg_pc, m_pc);
         check(rq, "write enable (R8)", {31'd0, dbg_we}, {31'd0, we});
         if (we) begin
            check(rq, "write index", {27'd0, dbg_waddr}, {27'd0, wa});
            check(rq, "write data", dbg_wdata, res);
            m_reg[wa] = res;
         end

         m_pc = nxt;
         @(negedge clk);
         check(pq, "next pc", dbg_pc, m_pc);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule